// File: doc/BRIEF.md
# MTP Memory Erase-Program-Verify Sequencer

This block takes a byte-wide many-time-programmable memory through a complete rewrite on its own. One start request triggers a chip erase, a blank check that reads every byte back, a program pass that writes each address in ascending order, and a final verify pass. During erase and program it drives the memory's active-low chip-enable, output-enable and write-enable strobes together with two high-voltage request flags. One flag asks for the raised level on the output-enable pin, the other for the raised level on address line 9. The analog supplies and the array itself lie outside the block.

A ready/valid source indexed by address supplies the bytes to write. The sequencer asks that source again for the same bytes when it verifies. Every timing interval is a parameter counted in clock cycles, each at least one cycle: high-voltage lead time, strobe setup, strobe hold, erase pulse, program pulse, recovery and read access. When the flow ends, the block raises done with exactly one of pass or fail. On a failure it also reports the address of the first byte that did not match.

Top module: `mtp_prog_seq`

## Requirements
- R1: `start` is accepted only while the block is idle or finished. A `start` that arrives during a flow has no effect: there is still exactly one erase pulse and one program pulse per address, and the verdict does not change.
- R2: Erase raises both high-voltage flags and drives chip-enable low, then gives exactly one write-enable low pulse lasting `ERASE_CYC` cycles.
- R3: Whenever chip-enable falls in a high-voltage phase, the output-enable high-voltage flag has already been active for at least `HV_SETUP_CYC` cycles. Chip-enable is low for at least `SETUP_CYC` cycles before each write-enable pulse.
- R4: Program raises only the output-enable flag, with the address-9 flag low. For each byte the block fetches its data from the source (`src_req` high with `src_addr`, answered by `src_valid` with `src_data`). It then drives the address and data (`mem_dq_oe`=1) and gives one write-enable pulse of `PROG_CYC` cycles. Address and data stay stable through the pulse and for `HOLD_CYC` cycles after write-enable rises.
- R5: Program pulses visit addresses 0 to 2^`ADDR_W`-1 in ascending order, one pulse each, with no wrap.
- R6: After each high-voltage phase both flags are released, and no read (output-enable low) starts until `RECOV_CYC` cycles have passed with the flags low.
- R7: The blank check reads every byte and compares it with all ones. A mismatch ends the flow with fail, and no program pulse is issued.
- R8: Verify re-fetches each byte from the source and compares it with the byte read back. The flow ends with pass only if every byte matches, and ends with fail at the first mismatch.
- R9: Each read holds chip-enable and output-enable low with both flags off, and samples `mem_din` only after the strobes and address have been applied for `ACCESS_CYC` cycles.
- R10: At the end, `done` is high with exactly one of `pass` and `fail`. All three hold until the next accepted `start`, and `done` is low one cycle after that start.
- R11: On a failure, `fail_addr` holds the address of the first mismatching byte and stays stable while finished.
- R12: After reset the strobes are high, both flags and `mem_dq_oe` are low, and `done`, `pass` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a full erase-program-verify flow |
| src_req | output | 1 | Request for the source byte at `src_addr` |
| src_addr | output | ADDR_W | Address of the requested source byte |
| src_valid | input | 1 | Source byte present on `src_data` |
| src_data | input | DATA_W | Source byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dout` onto the data pins |
| mem_din | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| hv_oe_req | output | 1 | Request raised voltage on the output-enable pin |
| hv_a9_req | output | 1 | Request raised voltage on address line 9 |
| done | output | 1 | Flow finished |
| pass | output | 1 | Finished with every byte matching |
| fail | output | 1 | Finished on a mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |

## Verification
The flow runs against a behavioural memory under four data patterns. A nibble-and-complement pattern catches address mix-ups. Alternating 55h/AAh catches single-bit adjacency faults. All zeros forces every bit to be programmed, and all ones gives program pulses that change nothing. The source answers either at once or after a delay that depends on the address, which separates a correct handshake from one that samples `src_data` too early. Faults are injected in two places: a byte that will not erase, to exercise the blank-check exit, and bits stuck at one, to exercise the verify exit and the capture of the first failing address. The memory model returns the complement of the stored byte until the access delay has elapsed, so a read sampled early turns into a mismatch.

// File: rtl/mtp_prog_pkg.sv
package mtp_prog_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_ER_HV,
    S_ER_CE,
    S_ER_PULSE,
    S_ER_HOLD,
    S_ER_REC,
    S_BC_RD,
    S_PG_HV,
    S_PG_FETCH,
    S_PG_SETUP,
    S_PG_PULSE,
    S_PG_HOLD,
    S_PG_REC,
    S_VF_FETCH,
    S_VF_RD,
    S_PASS,
    S_FAIL
  } seq_state_e;

  function automatic int unsigned cyc_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_read(seq_state_e s);
    return (s == S_BC_RD) || (s == S_VF_RD);
  endfunction

  function automatic logic is_finished(seq_state_e s);
    return (s == S_PASS) || (s == S_FAIL);
  endfunction

  function automatic logic can_start(seq_state_e s);
    return (s == S_IDLE) || is_finished(s);
  endfunction

endpackage

// File: rtl/mtp_phase_timer.sv
module mtp_phase_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q;

  assign expired = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  // R2
  expiry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> expired);

endmodule

// File: rtl/mtp_addr_walker.sv
module mtp_addr_walker #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  logic [ADDR_W-1:0] addr_q;

  assign addr    = addr_q;
  assign at_last = (addr_q == {ADDR_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (clear) addr_q <= '0;
    else if (step)  addr_q <= addr_q + 1'b1;
  end

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last);

  // R5
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/mtp_byte_checker.sv
module mtp_byte_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [ADDR_W-1:0] sample_addr,
  input  logic [DATA_W-1:0] got,
  input  logic [DATA_W-1:0] want,
  output logic              mismatch,
  output logic [ADDR_W-1:0] fail_addr
);

  logic [ADDR_W-1:0] fail_addr_q;

  assign mismatch  = sample && (got != want);
  assign fail_addr = fail_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail_addr_q <= '0;
    else if (clear)    fail_addr_q <= '0;
    else if (mismatch) fail_addr_q <= sample_addr;
  end

  // R11
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !clear) |=> (fail_addr_q == $past(sample_addr)));

endmodule

// File: rtl/mtp_prog_seq.sv
module mtp_prog_seq
  import mtp_prog_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int HV_SETUP_CYC = 2,
  parameter int SETUP_CYC    = 2,
  parameter int HOLD_CYC     = 2,
  parameter int ERASE_CYC    = 200,
  parameter int PROG_CYC     = 10,
  parameter int RECOV_CYC    = 4,
  parameter int ACCESS_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              hv_oe_req,
  output logic              hv_a9_req,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int unsigned LONGEST = cyc_max(
    cyc_max(cyc_max(ERASE_CYC, PROG_CYC), cyc_max(HV_SETUP_CYC, SETUP_CYC)),
    cyc_max(cyc_max(HOLD_CYC, RECOV_CYC), ACCESS_CYC));
  localparam int TMR_W = $clog2(LONGEST + 1);
  localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

  seq_state_e state_q, state_d;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] addr;
  logic [TMR_W-1:0]  limit;
  logic tmr_exp, at_last, mismatch;
  logic step, walk_clr, latch, restart;
  logic flow_start, busy, rd_sample;

  function automatic logic [TMR_W-1:0] phase_len(seq_state_e s);
    case (s)
      S_ER_HV, S_PG_HV:       return TMR_W'(HV_SETUP_CYC);
      S_ER_CE, S_PG_SETUP:    return TMR_W'(SETUP_CYC);
      S_ER_PULSE:             return TMR_W'(ERASE_CYC);
      S_PG_PULSE:             return TMR_W'(PROG_CYC);
      S_ER_HOLD, S_PG_HOLD:   return TMR_W'(HOLD_CYC);
      S_ER_REC, S_PG_REC:     return TMR_W'(RECOV_CYC);
      S_BC_RD, S_VF_RD:       return TMR_W'(ACCESS_CYC);
      default:                return TMR_W'(1);
    endcase
  endfunction

  assign limit      = phase_len(state_q);
  assign flow_start = can_start(state_q) && start;
  assign busy       = !can_start(state_q);
  assign rd_sample  = is_read(state_q) && tmr_exp;
  assign restart    = (state_d != state_q) || step;

  always_comb begin
    state_d  = state_q;
    step     = 1'b0;
    walk_clr = 1'b0;
    latch    = 1'b0;
    case (state_q)
      S_IDLE, S_PASS, S_FAIL:
        if (start) begin
          state_d  = S_ER_HV;
          walk_clr = 1'b1;
        end
      S_ER_HV:    if (tmr_exp) state_d = S_ER_CE;
      S_ER_CE:    if (tmr_exp) state_d = S_ER_PULSE;
      S_ER_PULSE: if (tmr_exp) state_d = S_ER_HOLD;
      S_ER_HOLD:  if (tmr_exp) state_d = S_ER_REC;
      S_ER_REC:   if (tmr_exp) state_d = S_BC_RD;
      S_BC_RD:
        if (tmr_exp) begin
          if (mismatch) state_d = S_FAIL;
          else if (at_last) begin
            state_d  = S_PG_HV;
            walk_clr = 1'b1;
          end else step = 1'b1;
        end
      S_PG_HV:    if (tmr_exp) state_d = S_PG_FETCH;
      S_PG_FETCH:
        if (src_valid) begin
          latch   = 1'b1;
          state_d = S_PG_SETUP;
        end
      S_PG_SETUP: if (tmr_exp) state_d = S_PG_PULSE;
      S_PG_PULSE: if (tmr_exp) state_d = S_PG_HOLD;
      S_PG_HOLD:
        if (tmr_exp) begin
          if (at_last) begin
            state_d  = S_PG_REC;
            walk_clr = 1'b1;
          end else begin
            step    = 1'b1;
            state_d = S_PG_FETCH;
          end
        end
      S_PG_REC:   if (tmr_exp) state_d = S_VF_FETCH;
      S_VF_FETCH:
        if (src_valid) begin
          latch   = 1'b1;
          state_d = S_VF_RD;
        end
      S_VF_RD:
        if (tmr_exp) begin
          if (mismatch)     state_d = S_FAIL;
          else if (at_last) state_d = S_PASS;
          else begin
            step    = 1'b1;
            state_d = S_VF_FETCH;
          end
        end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (latch) wdata_q <= src_data;
    end
  end

  mtp_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .limit(limit), .expired(tmr_exp)
  );

  mtp_addr_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .clear(walk_clr), .step(step),
    .addr(addr), .at_last(at_last)
  );

  mtp_byte_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
    .clk(clk), .rst_n(rst_n), .clear(flow_start), .sample(rd_sample),
    .sample_addr(addr), .got(mem_din),
    .want((state_q == S_BC_RD) ? BLANK : wdata_q),
    .mismatch(mismatch), .fail_addr(fail_addr)
  );

  // Strobe and flag decode, all from the registered state.
  always_comb begin
    mem_ce_n  = 1'b1;
    mem_oe_n  = 1'b1;
    mem_we_n  = 1'b1;
    hv_oe_req = 1'b0;
    hv_a9_req = 1'b0;
    mem_dq_oe = 1'b0;
    case (state_q)
      S_ER_HV:    begin hv_oe_req = 1'b1; hv_a9_req = 1'b1; end
      S_ER_CE, S_ER_HOLD: begin
        hv_oe_req = 1'b1; hv_a9_req = 1'b1; mem_ce_n = 1'b0;
      end
      S_ER_PULSE: begin
        hv_oe_req = 1'b1; hv_a9_req = 1'b1; mem_ce_n = 1'b0; mem_we_n = 1'b0;
      end
      S_PG_HV, S_PG_FETCH: hv_oe_req = 1'b1;
      S_PG_SETUP, S_PG_HOLD: begin
        hv_oe_req = 1'b1; mem_ce_n = 1'b0; mem_dq_oe = 1'b1;
      end
      S_PG_PULSE: begin
        hv_oe_req = 1'b1; mem_ce_n = 1'b0; mem_dq_oe = 1'b1; mem_we_n = 1'b0;
      end
      S_BC_RD, S_VF_RD: begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
      default: ;
    endcase
  end

  assign mem_addr = addr;
  assign mem_dout = wdata_q;
  assign src_req  = (state_q == S_PG_FETCH) || (state_q == S_VF_FETCH);
  assign src_addr = addr;
  assign done     = is_finished(state_q);
  assign pass     = (state_q == S_PASS);
  assign fail     = (state_q == S_FAIL);

  // R2
  erase_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_a9_req && !mem_we_n) |-> (hv_oe_req && !mem_ce_n));

  // R3
  hv_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && hv_oe_req) |-> $past(hv_oe_req));

  // R4
  we_low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dout)));

  // R4
  we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dout) && !mem_ce_n));

  // R6
  read_hv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!hv_oe_req && !hv_a9_req && !mem_ce_n));

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !$rose(hv_a9_req));

  // R10
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail)));

  // R10
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({pass, fail}));

  // R11
  fail_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> $stable(fail_addr));

endmodule

// File: tb/tb_mtp_prog_seq.sv
module tb_mtp_prog_seq;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HVS = 2, SET = 2, HLD = 2, ERS = 200, PRG = 10, REC = 4, ACC = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic src_req, src_valid = 1'b0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data = '0, mem_dout, mem_din = '0;
  logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, hv_oe_req, hv_a9_req;
  logic done, pass, fail;

  int n_checks = 0, n_fail = 0, cycles = 0;

  mtp_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .HV_SETUP_CYC(HVS), .SETUP_CYC(SET), .HOLD_CYC(HLD),
    .ERASE_CYC(ERS), .PROG_CYC(PRG), .RECOV_CYC(REC), .ACCESS_CYC(ACC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_req(src_req), .src_addr(src_addr),
    .src_valid(src_valid), .src_data(src_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dq_oe(mem_dq_oe), .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .hv_oe_req(hv_oe_req), .hv_a9_req(hv_a9_req), .done(done),
    .pass(pass), .fail(fail), .fail_addr(fail_addr)
  );

  always #5 clk = ~clk;

  // scenario configuration
  int pat_sel = 0, lat_mode = 0;
  int erase_stuck = -1, stuck_a = -1, stuck_b = -1;

  // model and monitor state
  logic [DW-1:0] mem [DEPTH];
  logic prev_we = 1'b1, prev_ce = 1'b1, prev_oe = 1'b1, fall_a9 = 1'b0;
  logic was_rd = 1'b0;
  int rd_run = 0, we_run = 0, ce_run = 0, hv_run = 0, off_run = 0, hold_left = 0;
  int src_wait = 0, erase_pulses = 0, prog_pulses = 0, viol = 0;
  logic [AW-1:0] last_rd_addr = '0, held_addr = '0;
  logic [DW-1:0] held_data = '0;

  function automatic logic [DW-1:0] pat_of(int sel, int a);
    case (sel)
      0: return DW'(((a & 15) << 4) | (~a & 15));
      1: return (a % 2 == 1) ? 8'hAA : 8'h55;
      2: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int lat_of(int mode, int a);
    return (mode == 0) ? 0 : (a % 3) + 1;
  endfunction

  task automatic note(input string msg);
    viol++;
    $display("monitor: %s at cycle %0d", msg, cycles);
  endtask

  always @(posedge clk) cycles++;

  always @(negedge clk) begin
    if (rst_n) begin
      // memory: erase / program on write-enable falling edge
      if (prev_we && !mem_we_n) begin
        fall_a9 = hv_a9_req;
        held_addr = mem_addr;
        held_data = mem_dout;
        we_run = 0;
        // R3: chip enable setup before write enable
        if (ce_run < SET) note("chip enable setup too short");
        if (!mem_ce_n && hv_oe_req && hv_a9_req) begin
          erase_pulses++;
          for (int i = 0; i < DEPTH; i++) mem[i] = (i == erase_stuck) ? 8'h7F : 8'hFF;
        end else if (!mem_ce_n && hv_oe_req && !hv_a9_req && mem_dq_oe) begin
          // R5: ascending order
          if (int'(mem_addr) != prog_pulses) note("program address out of order");
          prog_pulses++;
          mem[mem_addr] = mem[mem_addr] & mem_dout;
        end else note("write pulse without a valid mode");
      end
      if (!mem_we_n) begin
        we_run++;
        if (mem_addr != held_addr || (!fall_a9 && mem_dout != held_data)) note("address or data moved in pulse");
      end
      if (!prev_we && mem_we_n) begin
        // R2 / R4: pulse width
        if (we_run != (fall_a9 ? ERS : PRG)) note("write pulse width wrong");
        hold_left = HLD;
      end
      if (hold_left > 0) begin
        if (mem_addr != held_addr || mem_ce_n || (!fall_a9 && mem_dout != held_data)) note("hold after pulse too short");
        hold_left--;
      end
      // R3: high-voltage lead before chip enable falls
      if (prev_ce && !mem_ce_n && hv_oe_req && hv_run < HVS) note("high-voltage lead too short");
      if (!hv_oe_req) hv_run = 0; else if (mem_ce_n) hv_run++;
      if (mem_ce_n) ce_run = 0; else if (mem_we_n) ce_run++;
      // R6: recovery before a read
      if (prev_oe && !mem_oe_n && off_run < REC) note("read before recovery elapsed");
      if (hv_oe_req || hv_a9_req) off_run = 0; else if (mem_oe_n) off_run++;
      // R9: read data valid only after the access delay
      if (!mem_ce_n && !mem_oe_n && !hv_oe_req && !hv_a9_req) begin
        if (was_rd && mem_addr == last_rd_addr) rd_run++; else rd_run = 1;
        was_rd = 1'b1;
        last_rd_addr = mem_addr;
        begin
          logic [DW-1:0] v;
          v = mem[mem_addr];
          if (int'(mem_addr) == stuck_a || int'(mem_addr) == stuck_b) v = v | 8'h01;
          mem_din = (rd_run >= ACC) ? v : ~v;
        end
      end else begin
        was_rd = 1'b0;
        rd_run = 0;
        mem_din = 8'h5A;
      end
      // source
      if (!src_req || src_valid) begin
        src_valid = 1'b0;
        src_wait = 0;
      end else if (src_wait >= lat_of(lat_mode, int'(src_addr))) begin
        src_valid = 1'b1;
        src_data = pat_of(pat_sel, int'(src_addr));
      end else src_wait++;
      prev_we = mem_we_n;
      prev_ce = mem_ce_n;
      prev_oe = mem_oe_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R10", "watchdog waiting for done", n, 0);
  endtask

  task automatic prep(input int pat, input int lat, input int es, input int sa, input int sb);
    pat_sel = pat; lat_mode = lat; erase_stuck = es; stuck_a = sa; stuck_b = sb;
    erase_pulses = 0; prog_pulses = 0; viol = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(8'h3C ^ i);
  endtask

  task automatic check_contents(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != pat_of(pat_sel, i)) bad++;
    check(bad == 0, req, "bytes differing from source", bad, 0);
  endtask

  task automatic t_reset();
    // R12
    check(mem_ce_n && mem_oe_n && mem_we_n, "R12", "strobes after reset",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!hv_oe_req && !hv_a9_req && !mem_dq_oe, "R12", "flags after reset",
          {hv_oe_req, hv_a9_req, mem_dq_oe}, 0);
    check(!done && !pass && !fail, "R12", "verdict after reset", {done, pass, fail}, 0);
  endtask

  task automatic t_pass(input int pat, input int lat);
    prep(pat, lat, -1, -1, -1);
    pulse_start();
    check(!done, "R10", "done low after start", done, 0);
    wait_done();
    check(pass && !fail, "R8", "pass verdict", {pass, fail}, 2'b10);
    check(erase_pulses == 1, "R2", "erase pulse count", erase_pulses, 1);
    check(prog_pulses == DEPTH, "R5", "program pulse count", prog_pulses, DEPTH);
    check(viol == 0, "R4", "timing monitor violations (R3 R6 R9)", viol, 0);
    check_contents("R4");
  endtask

  task automatic t_busy_start();
    prep(1, 1, -1, -1, -1);
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();   // during the erase pulse
    repeat (400) @(negedge clk);
    pulse_start();   // during programming
    wait_done();
    check(erase_pulses == 1, "R1", "erase pulses with extra starts", erase_pulses, 1);
    check(prog_pulses == DEPTH, "R1", "program pulses with extra starts", prog_pulses, DEPTH);
    check(pass, "R1", "pass with extra starts", pass, 1);
    check(viol == 0, "R1", "timing monitor violations", viol, 0);
    repeat (50) @(negedge clk);
    check(done && pass && !fail, "R10", "verdict held while finished", {done, pass, fail}, 3'b110);
  endtask

  task automatic t_blank_fail();
    prep(0, 0, 6, -1, -1);
    pulse_start();
    check(!done, "R10", "done cleared on restart", done, 0);
    wait_done();
    check(fail && !pass, "R7", "blank check verdict", {pass, fail}, 2'b01);
    check(fail_addr == 4'd6, "R11", "blank check fail address", fail_addr, 6);
    check(prog_pulses == 0, "R7", "no program pulse after blank fail", prog_pulses, 0);
    repeat (30) @(negedge clk);
    check(fail_addr == 4'd6 && fail, "R11", "fail address held", fail_addr, 6);
  endtask

  task automatic t_verify_fail();
    prep(0, 1, -1, 9, 12);
    pulse_start();
    wait_done();
    check(fail && !pass, "R8", "verify verdict", {pass, fail}, 2'b01);
    check(fail_addr == 4'd9, "R11", "first mismatch address", fail_addr, 9);
    check(prog_pulses == DEPTH, "R8", "all bytes programmed before verify", prog_pulses, DEPTH);
    check(viol == 0, "R9", "timing monitor violations", viol, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pass(0, 0);
    t_busy_start();
    t_blank_fail();
    t_verify_fail();
    t_pass(2, 1);
    t_pass(3, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule